// File: doc/BRIEF.md
# Low-Power DRAM Power-Down Sequencer

This block sits on the controller side of a mobile DDR memory interface. It decides when the clock-enable pin may be pulled low for power-down or deep power-down, and when it may be raised again. It follows the controller's command stream and counts clock cycles against configured latencies. A write locks out power-down until its data burst and write recovery are complete. Activate and precharge commands hold back clock-change permission until their row timings have expired.

While the device sits in ordinary power-down, the block grants a clock-change permission flag to an external clock manager. That manager may then stop the clock or retune it. Two guard windows protect the clock-enable edges. The clock keeps its frequency for two cycles after the enable falls. The clock must be reported stable for two sampled cycles before the enable rises again.

Leaving deep power-down raises the enable, waits the configured input setup interval, and then issues a one-cycle request for full reinitialisation. The reinitialisation itself is done elsewhere. All outputs come from rising-edge flops or from state held in such flops, so the memory samples them cleanly on the rising clock. There is no data stream through the block: every pin is a plain level or a plain strobe.

Top module: `lpdram_pd_seq`

## Requirements
- R1: After reset, cke is 1, clk_chg_ok is 0 and reinit_req is 0.
- R2: When cmd_wr is sampled at edge E, cke cannot fall before edge E+N, where N = cfg_wl + 1 + cfg_bl/2 + cfg_twr. Here cfg_bl is the burst length in beats and cfg_twr is write recovery in whole cycles. With a power request held and nothing else blocking, cke falls exactly at edge E+N.
- R3: Every new cmd_wr restarts the lockout of R2, so a later write pushes the cke fall out to N edges after that later write.
- R4: While refresh_due is 1, cke stays 1 even with a power request pending. cke falls at the first edge where refresh_due is sampled 0, provided the other conditions hold.
- R5: clk_chg_ok is never 1 during the first two cycles of cke low. With no timing pending, it rises two edges after the edge at which cke fell.
- R6: clk_chg_ok stays 0 until cfg_trcd cycles have passed since the last cmd_act and cfg_trp cycles have passed since the last cmd_pre. A strobe sampled at edge A permits clk_chg_ok from edge A+t at the earliest, where t is the matching timing.
- R7: With cfg_eight_bank = 1, a per-bank refresh (cmd_ref_bank) does not affect clk_chg_ok. With cfg_eight_bank = 0, a per-bank refresh withholds clk_chg_ok until the next ordinary power-down has ended and cke is back at 1.
- R8: When pd_req is sampled 0 during power-down, clk_chg_ok drops after that edge. cke rises at the edge after clk_stable has been sampled 1 at two consecutive edges; an edge that samples clk_stable as 0 restarts the count.
- R9: dpd_req takes priority over pd_req. Deep power-down entry is gated by the same write lockout and refresh_due as R2 and R4. cke then stays 0, and clk_chg_ok stays 0 throughout.
- R10: Deep power-down ends when dpd_req is 0 and clk_stable is sampled 1 at two consecutive edges; cke rises at the following edge. Exactly cfg_tiscke edges after that rise, reinit_req is 1 for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_req | input | 1 | Level request for ordinary power-down |
| dpd_req | input | 1 | Level request for deep power-down |
| refresh_due | input | 1 | Refresh owed; blocks power-down entry |
| clk_stable | input | 1 | Clock manager reports a stable clock |
| cmd_wr | input | 1 | A WRITE was issued this cycle |
| cmd_act | input | 1 | An ACTIVATE was issued this cycle |
| cmd_pre | input | 1 | A PRECHARGE was issued this cycle |
| cmd_ref_bank | input | 1 | A per-bank REFRESH was issued this cycle |
| cfg_wl | input | WL_W | Write latency in cycles |
| cfg_bl | input | BL_W | Burst length in beats |
| cfg_twr | input | TWR_W | Write recovery in cycles |
| cfg_trcd | input | TRCD_W | Activate-to-column delay in cycles |
| cfg_trp | input | TRP_W | Precharge period in cycles |
| cfg_tiscke | input | TIS_W | Clock-enable setup interval on deep exit, in cycles |
| cfg_eight_bank | input | 1 | Device has eight banks |
| cke | output | 1 | Clock enable to the memory |
| clk_chg_ok | output | 1 | Clock may be stopped or retuned |
| reinit_req | output | 1 | One-cycle request for full reinitialisation |

## Verification
The assertions assume the configuration inputs hold still while the block is active, and that cfg_tiscke is at least 1. They also assume the controller issues commands only while cke is high; the age counters in the checker do not model commands that arrive during power-down. The bench sets every cfg_* value once, before reset is released. It changes cfg_eight_bank only while the block is idle, and it drives command strobes only in cycles where cke is still 1. The clock-stable input is dropped only while an exit guard is in progress, which exercises the restart rule of R8.

// File: rtl/lpdram_pd_pkg.sv
package lpdram_pd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_PD,
    ST_PD_ENTRY,
    ST_PD,
    ST_EXIT_GUARD,
    ST_WAIT_DPD,
    ST_DPD,
    ST_DPD_EXIT
  } pd_state_e;

  localparam int unsigned TMR_WR  = 0;
  localparam int unsigned TMR_ACT = 1;
  localparam int unsigned TMR_PRE = 2;
  localparam int unsigned NUM_TMR = 3;

endpackage

// File: rtl/lpdram_pd_countdown.sv
module lpdram_pd_countdown #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/lpdram_pd_timers.sv
module lpdram_pd_timers
  import lpdram_pd_pkg::*;
#(
  parameter int unsigned WL_W   = 4,
  parameter int unsigned BL_W   = 5,
  parameter int unsigned TWR_W  = 4,
  parameter int unsigned TRCD_W = 4,
  parameter int unsigned TRP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              cmd_act,
  input  logic              cmd_pre,
  input  logic [WL_W-1:0]   cfg_wl,
  input  logic [BL_W-1:0]   cfg_bl,
  input  logic [TWR_W-1:0]  cfg_twr,
  input  logic [TRCD_W-1:0] cfg_trcd,
  input  logic [TRP_W-1:0]  cfg_trp,
  output logic              wr_ok,
  output logic              act_done,
  output logic              pre_done
);
  localparam int unsigned M1    = (WL_W > TWR_W) ? WL_W : TWR_W;
  localparam int unsigned M2    = (M1 > BL_W) ? M1 : BL_W;
  localparam int unsigned M3    = (M2 > TRCD_W) ? M2 : TRCD_W;
  localparam int unsigned MAXW  = (M3 > TRP_W) ? M3 : TRP_W;
  localparam int unsigned CNT_W = MAXW + 2;

  logic [NUM_TMR-1:0] ld;
  logic [NUM_TMR-1:0] zr;
  logic [CNT_W-1:0]   ld_val [NUM_TMR];

  // The write countdown holds one less than the lockout length so that
  // its zero state marks the first edge at which cke may fall.
  always_comb begin
    ld[TMR_WR]      = cmd_wr;
    ld[TMR_ACT]     = cmd_act;
    ld[TMR_PRE]     = cmd_pre;
    ld_val[TMR_WR]  = CNT_W'(cfg_wl) + CNT_W'(cfg_bl >> 1) + CNT_W'(cfg_twr);
    ld_val[TMR_ACT] = CNT_W'(cfg_trcd);
    ld_val[TMR_PRE] = CNT_W'(cfg_trp);
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    lpdram_pd_countdown #(.W(CNT_W)) u_cd (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld[i]),
      .load_val (ld_val[i]),
      .zero     (zr[i])
    );
  end

  assign wr_ok    = zr[TMR_WR] && !cmd_wr;
  assign act_done = zr[TMR_ACT];
  assign pre_done = zr[TMR_PRE];
endmodule

// File: rtl/lpdram_pd_fsm.sv
module lpdram_pd_fsm
  import lpdram_pd_pkg::*;
#(
  parameter int unsigned TIS_W     = 8,
  parameter int unsigned GUARD_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_req,
  input  logic             dpd_req,
  input  logic             refresh_due,
  input  logic             clk_stable,
  input  logic             wr_ok,
  input  logic             act_done,
  input  logic             pre_done,
  input  logic             bank_block,
  input  logic [TIS_W-1:0] cfg_tiscke,
  output logic             cke,
  output logic             clk_chg_ok,
  output logic             reinit_req,
  output logic             pd_leave
);
  localparam int unsigned GW = $clog2(GUARD_CYC + 1);

  pd_state_e      st_q;
  logic           cke_q;
  logic           rei_q;
  logic [GW-1:0]  guard_q;
  logic [GW-1:0]  stab_q;
  logic [TIS_W:0] tis_q;

  logic entry_ok;
  assign entry_ok = wr_ok && !refresh_due;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cke_q   <= 1'b1;
      rei_q   <= 1'b0;
      guard_q <= '0;
      stab_q  <= '0;
      tis_q   <= '0;
    end else begin
      rei_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (dpd_req)     st_q <= ST_WAIT_DPD;
          else if (pd_req) st_q <= ST_WAIT_PD;
        end
        ST_WAIT_PD: begin
          if (dpd_req)      st_q <= ST_WAIT_DPD;
          else if (!pd_req) st_q <= ST_IDLE;
          else if (entry_ok) begin
            st_q    <= ST_PD_ENTRY;
            cke_q   <= 1'b0;
            guard_q <= '0;
          end
        end
        ST_PD_ENTRY: begin
          if (guard_q == GW'(GUARD_CYC - 1)) st_q <= ST_PD;
          else guard_q <= guard_q + 1'b1;
        end
        ST_PD: begin
          if (!pd_req) begin
            st_q   <= ST_EXIT_GUARD;
            stab_q <= '0;
          end
        end
        ST_EXIT_GUARD: begin
          if (stab_q == GW'(GUARD_CYC)) begin
            st_q  <= ST_IDLE;
            cke_q <= 1'b1;
          end else if (clk_stable) stab_q <= stab_q + 1'b1;
          else stab_q <= '0;
        end
        ST_WAIT_DPD: begin
          if (!dpd_req) st_q <= ST_IDLE;
          else if (entry_ok) begin
            st_q   <= ST_DPD;
            cke_q  <= 1'b0;
            stab_q <= '0;
          end
        end
        ST_DPD: begin
          if (stab_q == GW'(GUARD_CYC)) begin
            st_q  <= ST_DPD_EXIT;
            cke_q <= 1'b1;
            tis_q <= '0;
          end else if (!dpd_req && clk_stable) stab_q <= stab_q + 1'b1;
          else stab_q <= '0;
        end
        ST_DPD_EXIT: begin
          if ((tis_q + 1'b1) >= {1'b0, cfg_tiscke}) begin
            st_q  <= ST_IDLE;
            rei_q <= 1'b1;
          end else tis_q <= tis_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cke        = cke_q;
  assign reinit_req = rei_q;
  assign clk_chg_ok = (st_q == ST_PD) && act_done && pre_done && !bank_block;
  assign pd_leave   = (st_q == ST_EXIT_GUARD) && (stab_q == GW'(GUARD_CYC));
endmodule

// File: rtl/lpdram_pd_seq.sv
module lpdram_pd_seq #(
  parameter int unsigned WL_W      = 4,
  parameter int unsigned BL_W      = 5,
  parameter int unsigned TWR_W     = 4,
  parameter int unsigned TRCD_W    = 4,
  parameter int unsigned TRP_W     = 4,
  parameter int unsigned TIS_W     = 8,
  parameter int unsigned GUARD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_req,
  input  logic              dpd_req,
  input  logic              refresh_due,
  input  logic              clk_stable,
  input  logic              cmd_wr,
  input  logic              cmd_act,
  input  logic              cmd_pre,
  input  logic              cmd_ref_bank,
  input  logic [WL_W-1:0]   cfg_wl,
  input  logic [BL_W-1:0]   cfg_bl,
  input  logic [TWR_W-1:0]  cfg_twr,
  input  logic [TRCD_W-1:0] cfg_trcd,
  input  logic [TRP_W-1:0]  cfg_trp,
  input  logic [TIS_W-1:0]  cfg_tiscke,
  input  logic              cfg_eight_bank,
  output logic              cke,
  output logic              clk_chg_ok,
  output logic              reinit_req
);
  logic wr_ok, act_done, pre_done, pd_leave;
  logic bank_block_q;

  lpdram_pd_timers #(
    .WL_W(WL_W), .BL_W(BL_W), .TWR_W(TWR_W), .TRCD_W(TRCD_W), .TRP_W(TRP_W)
  ) u_timers (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (cmd_wr),
    .cmd_act  (cmd_act),
    .cmd_pre  (cmd_pre),
    .cfg_wl   (cfg_wl),
    .cfg_bl   (cfg_bl),
    .cfg_twr  (cfg_twr),
    .cfg_trcd (cfg_trcd),
    .cfg_trp  (cfg_trp),
    .wr_ok    (wr_ok),
    .act_done (act_done),
    .pre_done (pre_done)
  );

  // A per-bank refresh on a device without eight banks is not a permitted
  // in-flight operation; it blocks clock changes until power-down ends.
  always_ff @(posedge clk) begin
    if (!rst_n)                             bank_block_q <= 1'b0;
    else if (cmd_ref_bank && !cfg_eight_bank) bank_block_q <= 1'b1;
    else if (pd_leave)                      bank_block_q <= 1'b0;
  end

  lpdram_pd_fsm #(.TIS_W(TIS_W), .GUARD_CYC(GUARD_CYC)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pd_req      (pd_req),
    .dpd_req     (dpd_req),
    .refresh_due (refresh_due),
    .clk_stable  (clk_stable),
    .wr_ok       (wr_ok),
    .act_done    (act_done),
    .pre_done    (pre_done),
    .bank_block  (bank_block_q),
    .cfg_tiscke  (cfg_tiscke),
    .cke         (cke),
    .clk_chg_ok  (clk_chg_ok),
    .reinit_req  (reinit_req),
    .pd_leave    (pd_leave)
  );
endmodule

// File: rtl/lpdram_pd_seq_chk.sv
module lpdram_pd_seq_chk #(
  parameter int unsigned WL_W   = 4,
  parameter int unsigned BL_W   = 5,
  parameter int unsigned TWR_W  = 4,
  parameter int unsigned TRCD_W = 4,
  parameter int unsigned TRP_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              refresh_due,
  input logic              clk_stable,
  input logic              cmd_wr,
  input logic              cmd_act,
  input logic              cmd_pre,
  input logic [WL_W-1:0]   cfg_wl,
  input logic [BL_W-1:0]   cfg_bl,
  input logic [TWR_W-1:0]  cfg_twr,
  input logic [TRCD_W-1:0] cfg_trcd,
  input logic [TRP_W-1:0]  cfg_trp,
  input logic              cke,
  input logic              clk_chg_ok,
  input logic              reinit_req
);
  logic [7:0] wr_age, act_age, pre_age;
  logic [7:0] wr_need;

  assign wr_need = 8'(cfg_wl) + 8'd1 + 8'(cfg_bl >> 1) + 8'(cfg_twr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_age  <= 8'hFF;
      act_age <= 8'hFF;
      pre_age <= 8'hFF;
    end else begin
      wr_age  <= cmd_wr  ? 8'd0 : (wr_age  == 8'hFF ? wr_age  : wr_age  + 8'd1);
      act_age <= cmd_act ? 8'd0 : (act_age == 8'hFF ? act_age : act_age + 8'd1);
      pre_age <= cmd_pre ? 8'd0 : (pre_age == 8'hFF ? pre_age : pre_age + 8'd1);
    end
  end

  // R2, R3: cke falls only once the latest write has fully recovered
  p_wr_lockout_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (wr_age >= wr_need));

  // R4: a pending refresh keeps cke high
  p_refresh_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && refresh_due) |=> cke);

  // R5: permission only after two full cycles of cke low
  p_chg_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_chg_ok |-> (!cke && !$past(cke) && !$past(cke, 2)));

  // R6: row timings satisfied whenever permission is given
  p_chg_rowtime_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clk_chg_ok |-> ((act_age >= 8'(cfg_trcd)) && (pre_age >= 8'(cfg_trp))));

  // R8, R10: cke rises only after two sampled stable-clock cycles
  p_exit_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> ($past(clk_stable, 2) && $past(clk_stable, 3)));

  // R10: reinitialisation request is a single-cycle pulse with cke high
  p_reinit_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_req |-> (cke && !clk_chg_ok) ##1 !reinit_req);
endmodule

bind lpdram_pd_seq lpdram_pd_seq_chk #(
  .WL_W(WL_W), .BL_W(BL_W), .TWR_W(TWR_W), .TRCD_W(TRCD_W), .TRP_W(TRP_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .refresh_due (refresh_due),
  .clk_stable  (clk_stable),
  .cmd_wr      (cmd_wr),
  .cmd_act     (cmd_act),
  .cmd_pre     (cmd_pre),
  .cfg_wl      (cfg_wl),
  .cfg_bl      (cfg_bl),
  .cfg_twr     (cfg_twr),
  .cfg_trcd    (cfg_trcd),
  .cfg_trp     (cfg_trp),
  .cke         (cke),
  .clk_chg_ok  (clk_chg_ok),
  .reinit_req  (reinit_req)
);

// File: tb/lpdram_pd_seq_bench.sv
`timescale 1ns/1ps
module lpdram_pd_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_req = 0, dpd_req = 0, refresh_due = 0, clk_stable = 1;
  logic cmd_wr = 0, cmd_act = 0, cmd_pre = 0, cmd_ref_bank = 0;
  logic [3:0] cfg_wl = 4'd3;
  logic [4:0] cfg_bl = 5'd8;
  logic [3:0] cfg_twr = 4'd4;
  logic [3:0] cfg_trcd = 4'd5;
  logic [3:0] cfg_trp = 4'd4;
  logic [7:0] cfg_tiscke = 8'd6;
  logic cfg_eight_bank = 1'b1;
  logic cke, clk_chg_ok, reinit_req;

  always #2.5 clk = ~clk;

  lpdram_pd_seq u_lpdram_pd_seq (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .dpd_req(dpd_req),
    .refresh_due(refresh_due), .clk_stable(clk_stable),
    .cmd_wr(cmd_wr), .cmd_act(cmd_act), .cmd_pre(cmd_pre),
    .cmd_ref_bank(cmd_ref_bank), .cfg_wl(cfg_wl), .cfg_bl(cfg_bl),
    .cfg_twr(cfg_twr), .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp),
    .cfg_tiscke(cfg_tiscke), .cfg_eight_bank(cfg_eight_bank),
    .cke(cke), .clk_chg_ok(clk_chg_ok), .reinit_req(reinit_req)
  );

  typedef struct {
    int    at;
    int    sig;   // 0 cke, 1 clk_chg_ok, 2 reinit_req
    logic  val;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic sig_val(int s);
    case (s)
      0: return cke;
      1: return clk_chg_ok;
      default: return reinit_req;
    endcase
  endfunction

  function automatic string sig_name(int s);
    case (s)
      0: return "cke";
      1: return "clk_chg_ok";
      default: return "reinit_req";
    endcase
  endfunction

  // driver side: expectation pushed relative to the current negedge
  task automatic expect_at(int dly, int s, logic v, string tag);
    exp_t e;
    e.at = cyc + dly; e.sig = s; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick(int k);
    repeat (k) @(negedge clk);
  endtask

  // monitor: pops every expectation due on this cycle
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].at == cyc) begin
        logic got;
        got = sig_val(q[i].sig);
        checks++;
        if (got !== q[i].val) begin
          errors++;
          $display("FAIL %s: %s actual=%b expected=%b at cycle %0d",
                   q[i].tag, sig_name(q[i].sig), got, q[i].val, cyc);
        end
        q.delete(i);
      end
    end
  end

  // leave power-down with a steady clock (R8 timing)
  task automatic pd_exit(string tag);
    pd_req = 0;
    expect_at(1, 1, 1'b0, tag);
    expect_at(3, 0, 1'b0, tag);
    expect_at(4, 0, 1'b1, tag);
    tick(6);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    expect_at(1, 0, 1'b1, "R1");
    expect_at(1, 1, 1'b0, "R1");
    expect_at(1, 2, 1'b0, "R1");
    tick(4);

    // R2 write lockout (N = 3+1+4+4 = 12), R5 guard after fall
    cmd_wr = 1; pd_req = 1;
    expect_at(12, 0, 1'b1, "R2");
    expect_at(13, 0, 1'b0, "R2");
    expect_at(14, 1, 1'b0, "R5");
    expect_at(15, 1, 1'b1, "R5");
    tick(1); cmd_wr = 0;
    tick(20);
    pd_exit("R8");

    // R3 a second write restarts the lockout
    cmd_wr = 1; pd_req = 1;
    tick(1); cmd_wr = 0;
    tick(4); cmd_wr = 1;
    expect_at(8, 0, 1'b1, "R3");
    expect_at(12, 0, 1'b1, "R3");
    expect_at(13, 0, 1'b0, "R3");
    tick(1); cmd_wr = 0;
    tick(20);
    pd_exit("R8");

    // R4 refresh_due holds cke high
    refresh_due = 1; pd_req = 1;
    expect_at(10, 0, 1'b1, "R4");
    tick(12);
    refresh_due = 0;
    expect_at(1, 0, 1'b0, "R4");
    expect_at(2, 1, 1'b0, "R5");
    expect_at(3, 1, 1'b1, "R5");
    tick(6);
    pd_exit("R8");

    // R6 activate timing
    cmd_act = 1; pd_req = 1;
    expect_at(2, 0, 1'b0, "R6");
    expect_at(5, 1, 1'b0, "R6");
    expect_at(6, 1, 1'b1, "R6");
    tick(1); cmd_act = 0;
    tick(8);
    pd_exit("R8");

    // R6 precharge timing
    cmd_pre = 1; pd_req = 1;
    expect_at(4, 1, 1'b0, "R6");
    expect_at(5, 1, 1'b1, "R6");
    tick(1); cmd_pre = 0;
    tick(8);
    pd_exit("R8");

    // R7 per-bank refresh with fewer than eight banks blocks permission
    cfg_eight_bank = 0;
    cmd_ref_bank = 1; pd_req = 1;
    expect_at(2, 0, 1'b0, "R7");
    expect_at(4, 1, 1'b0, "R7");
    expect_at(9, 1, 1'b0, "R7");
    tick(1); cmd_ref_bank = 0;
    tick(10);
    pd_exit("R7");
    pd_req = 1;
    expect_at(4, 1, 1'b1, "R7");
    tick(6);
    pd_exit("R8");
    cfg_eight_bank = 1;
    tick(1);

    // R7 per-bank refresh with eight banks does not block
    cmd_ref_bank = 1; pd_req = 1;
    expect_at(4, 1, 1'b1, "R7");
    tick(1); cmd_ref_bank = 0;
    tick(6);
    pd_exit("R8");

    // R8 unstable clock delays cke rise
    pd_req = 1;
    tick(8);
    clk_stable = 0; pd_req = 0;
    expect_at(1, 1, 1'b0, "R8");
    expect_at(6, 0, 1'b0, "R8");
    tick(6);
    clk_stable = 1;
    expect_at(2, 0, 1'b0, "R8");
    expect_at(3, 0, 1'b1, "R8");
    tick(6);

    // R9 deep power-down: priority, write gating, no permission
    cmd_wr = 1; dpd_req = 1; pd_req = 1;
    expect_at(12, 0, 1'b1, "R9");
    expect_at(13, 0, 1'b0, "R9");
    expect_at(16, 1, 1'b0, "R9");
    expect_at(20, 1, 1'b0, "R9");
    tick(1); cmd_wr = 0;
    tick(22);
    // R10 deep exit and reinit pulse after tISCKE = 6
    dpd_req = 0; pd_req = 0;
    expect_at(2, 0, 1'b0, "R10");
    expect_at(3, 0, 1'b1, "R10");
    expect_at(8, 2, 1'b0, "R10");
    expect_at(9, 2, 1'b1, "R10");
    expect_at(10, 2, 1'b0, "R10");
    tick(14);

    for (int k = 0; k < 50 && q.size() != 0; k++) tick(1);
    foreach (q[i]) begin
      errors++;
      checks++;
      $display("FAIL %s: %s actual=unchecked expected=%b", q[i].tag,
               sig_name(q[i].sig), q[i].val);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1-path: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule